// File: doc/BRIEF.md
# Time-Interleaved Multiply-Accumulate Datapath

This block keeps a full-rate stream of multiply-accumulate operations flowing while each arithmetic engine works at a fraction of that rate. Operands enter one set per cycle. They are dealt out in turn to `M` identical sequential engines. Each engine is enabled for loading only once every `M` cycles and has `M` cycles to finish its product. An output selector collects the finished results one per cycle, in the order the operands arrived. Each engine computes `a*b + c` by handling one slice of `b` per step. The engine therefore has a short logic depth, and it pays for that with more cycles.

The stream interfaces use valid/ready handshakes.

Back-pressure is global:
- `in_ready` follows `out_ready`.
- In a cycle where `out_ready` is low, the whole pipeline holds its state.
- In a cycle where `out_ready` is low, no operand is taken.
- In a cycle where `out_ready` is low, the output holds its valid flag and its data.

A cycle in which `out_ready` is high is an advancing cycle. An advancing cycle with `in_valid` low is a bubble. A bubble occupies its slot and comes out as an invalid output slot. Reset is synchronous and active high.

Top module: `interleaved_mac`

## Requirements
- R1: An operand set is taken exactly in cycles where `in_valid` and `in_ready` are both high, and `in_ready` always equals `out_ready`.
- R2: Every valid result equals `in_a*in_b + in_c` computed exactly, in `2*W+1` bits, with no truncation, including when all operands are at their maximum values.
- R3: A valid result appears M+1 advancing cycles after its operands were taken. Once the first advancing edge after the operands has passed, a result appears on the output after M further advancing edges.
- R4: Results leave in the same order as their operands entered, with no loss and no duplication.
- R5: An advancing cycle with `in_valid` low produces an output slot with `out_valid` low, M+1 advancing cycles later.
- R6: Advancing slot n, counted from reset, is given to engine n mod M. An engine is loaded only after it has completed all M steps of its previous operation, and at most one engine loads per cycle.
- R7: While `out_ready` is low, `out_valid` and `out_result` stay unchanged, and no in-flight operation advances or is lost.
- R8: After a cycle with `rst` high, `out_valid` is low. Operations in flight at reset never appear at the output. Engine 0 takes the first slot after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Block can take an operand set this cycle |
| in_a | input | W | Multiplicand |
| in_b | input | W | Multiplier |
| in_c | input | 2*W | Addend |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result; also advances the pipeline |
| out_result | output | 2*W+1 | `a*b + c` |

## Verification
The hardest situation to reach from the ports is a stall that arrives while each engine is part-way through its steps, with bubbles mixed into the slots. In that state a wrong phase or a lost step is hidden unless the result is compared later. The stimulus therefore runs long stretches with random bubbles and random `out_ready` drops together, so that stalls land in every phase of every engine. It also applies a reset in the middle of a dense stream, which checks that work in flight is discarded and that the phase restarts at engine 0.

// File: rtl/tid_pkg.sv
package tid_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/tid_phase.sv
module tid_phase #(
  parameter int M  = 2,
  localparam int PW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] phase,
  output logic [M-1:0]  load_en
);
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (adv) phase <= (phase == PW'(M - 1)) ? '0 : phase + 1'b1;
  end

  for (genvar k = 0; k < M; k++) begin : g_en
    assign load_en[k] = adv && (phase == PW'(k));
  end

  assert_one_load_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_en));
endmodule

// File: rtl/tid_unit.sv
module tid_unit #(
  parameter int W = 8,
  parameter int M = 2,
  localparam int RW  = 2 * W + 1,
  localparam int CH  = tid_pkg::ceil_div(W, M),
  localparam int BPW = CH * M,
  localparam int SW  = $clog2(M + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          load,
  input  logic          in_valid,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [2*W-1:0] in_c,
  output logic          done,
  output logic          res_valid,
  output logic [RW-1:0] result
);
  logic [SW-1:0]  step;
  logic [RW-1:0]  a_sh;
  logic [BPW-1:0] b_rem;
  logic [RW-1:0]  acc;
  logic           vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      step  <= SW'(M);
      vld   <= 1'b0;
      acc   <= '0;
      a_sh  <= '0;
      b_rem <= '0;
    end else if (adv) begin
      if (load) begin
        vld   <= in_valid;
        acc   <= RW'(in_c) + RW'(in_a) * RW'(in_b[CH-1:0]);
        a_sh  <= RW'(in_a) << CH;
        b_rem <= BPW'(in_b) >> CH;
        step  <= SW'(1);
      end else if (step != SW'(M)) begin
        acc   <= acc + a_sh * RW'(b_rem[CH-1:0]);
        a_sh  <= a_sh << CH;
        b_rem <= b_rem >> CH;
        step  <= step + 1'b1;
      end
    end
  end

  assign done      = (step == SW'(M));
  assign res_valid = vld;
  assign result    = acc;

  assert_load_after_done_R6: assert property (@(posedge clk) disable iff (rst)
    load |-> done);
  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(acc) && $stable(step));
endmodule

// File: rtl/tid_merge.sv
module tid_merge #(
  parameter int M  = 2,
  parameter int RW = 17,
  localparam int PW = (M > 1) ? $clog2(M) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic [PW-1:0]        sel,
  input  logic [M-1:0]         done,
  input  logic [M-1:0]         res_valid,
  input  logic [M-1:0][RW-1:0] result,
  output logic                 out_valid,
  output logic [RW-1:0]        out_result
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else if (adv) begin
      out_valid  <= res_valid[sel];
      out_result <= result[sel];
    end
  end

  assert_pick_finished_R3: assert property (@(posedge clk) disable iff (rst)
    adv |-> done[sel]);
  assert_out_stall_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(out_valid) && $stable(out_result));
endmodule

// File: rtl/interleaved_mac.sv
module interleaved_mac #(
  parameter int W = 8,
  parameter int M = 2,
  localparam int RW = 2 * W + 1,
  localparam int PW = (M > 1) ? $clog2(M) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  input  logic [2*W-1:0] in_c,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [RW-1:0]  out_result
);
  initial assert (M >= 2) else $error("M must be at least 2");

  logic                 adv;
  logic [PW-1:0]        phase;
  logic [M-1:0]         load_en;
  logic [M-1:0]         done;
  logic [M-1:0]         res_valid;
  logic [M-1:0][RW-1:0] result;

  assign adv      = out_ready;
  assign in_ready = out_ready;

  tid_phase #(.M(M)) u_phase (
    .clk(clk), .rst(rst), .adv(adv), .phase(phase), .load_en(load_en)
  );

  for (genvar k = 0; k < M; k++) begin : g_unit
    tid_unit #(.W(W), .M(M)) u_unit (
      .clk(clk), .rst(rst), .adv(adv), .load(load_en[k]),
      .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_c(in_c),
      .done(done[k]), .res_valid(res_valid[k]), .result(result[k])
    );
  end

  tid_merge #(.M(M), .RW(RW)) u_merge (
    .clk(clk), .rst(rst), .adv(adv), .sel(phase), .done(done),
    .res_valid(res_valid), .result(result),
    .out_valid(out_valid), .out_result(out_result)
  );

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/interleaved_mac_bench.sv
module interleaved_mac_bench;
  localparam int W  = 8;
  localparam int M  = 2;
  localparam int RW = 2 * W + 1;

  typedef struct {
    bit      v;
    longint  r;
  } slot_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [W-1:0]   in_a = '0;
  logic [W-1:0]   in_b = '0;
  logic [2*W-1:0] in_c = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [RW-1:0]  out_result;

  int checks = 0;
  int fails  = 0;
  string tag = "R8";
  int mode_max = 0;

  slot_t q[$];
  slot_t exp_now = '{v: 1'b0, r: 0};

  always #10 clk = ~clk;

  interleaved_mac #(.W(W), .M(M)) u_interleaved_mac (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result)
  );

  // Behavioural model: every advancing slot enters a queue; the slot taken
  // M+1 advancing cycles earlier is what the output must show.
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      exp_now = '{v: 1'b0, r: 0};
    end else if (out_ready) begin
      slot_t s;
      s.v = in_valid;
      s.r = longint'(in_a) * longint'(in_b) + longint'(in_c);
      q.push_back(s);
      if (q.size() > M) exp_now = q.pop_front();
    end
  end

  task automatic check_outputs();
    checks++;
    if (in_ready !== out_ready) begin
      fails++;
      $display("FAIL R1 in_ready: actual %0b expected %0b", in_ready, out_ready);
    end
    checks++;
    if (out_valid !== exp_now.v) begin
      fails++;
      $display("FAIL %s out_valid: actual %0b expected %0b", tag, out_valid, exp_now.v);
    end else if (exp_now.v && longint'(out_result) != exp_now.r) begin
      fails++;
      $display("FAIL %s out_result: actual %0d expected %0d", tag, out_result, exp_now.r);
    end
  endtask

  task automatic run(input int n, input int pct_bubble, input int pct_stall);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_outputs();
      in_valid  = ($urandom_range(99) >= pct_bubble);
      out_ready = ($urandom_range(99) >= pct_stall);
      if (mode_max != 0) begin
        in_a = '1; in_b = '1; in_c = '1;
      end else begin
        in_a = W'($urandom); in_b = W'($urandom); in_c = (2*W)'($urandom);
      end
    end
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R8 out_valid in reset: actual %0b expected 0", out_valid);
      end
    end
    rst = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    tag = "R8";
    do_reset(3);
    tag = "R2 R3 R4 R6 full rate";
    run(400, 0, 0);
    tag = "R5 bubbles";
    run(600, 35, 0);
    tag = "R7 stalls";
    run(600, 0, 40);
    tag = "R5 R7 mixed";
    run(1500, 30, 30);
    tag = "R2 max operands";
    mode_max = 1;
    run(100, 10, 10);
    mode_max = 0;
    tag = "R8 reset mid-stream";
    out_ready = 1'b1; in_valid = 1'b1;
    do_reset(1);
    run(300, 0, 0);
    tag = "R8 reset during stall";
    out_ready = 1'b0;
    do_reset(2);
    run(500, 20, 20);
    finish_up();
  end
endmodule